// File: doc/BRIEF.md
# Synchronized Peripheral Control Register

This block is the main control word of a peripheral. Software reaches it over a plain register port in the bus clock domain. It holds three things: a configuration field, a run bit that switches the peripheral on, and a self-clearing reset request. The run bit and the reset request each reach the core clock domain through a level handshake. While that handshake is in flight, a busy flag stays raised. The flag drops only when the core's acknowledgement has come back across to the bus side.

The configuration field is guarded. It accepts writes only while the peripheral is fully stopped, which means the run bit is clear and the core no longer reports itself as running. A reset request takes priority over everything else in the same write. It clears the word at once and keeps the block in a reset phase until the core has seen it. During that phase every write is refused with a bus error, and reads return only the reset-in-progress indication.

Top module: `ctl_sync_reg`

## Requirements
- R1: After the bus and core resets, `rdata` is 0, `cfg_q` is 0, `en_busy`, `rst_busy`, `bus_err` and `core_en` are all 0.
- R2: A write with bit 0 set, accepted outside the reset phase, raises `rst_busy` and clears the run bit and the configuration in the next cycle. Every other bit of that write is discarded. The core then sees the run bit low.
- R3: A write with bit 0 clear does not start the reset phase.
- R4: The reset phase ends by itself once the core has acknowledged the request, within 30 bus cycles. `core_rst` is high for part of the phase, and afterwards the word reads 0.
- R5: A write during the reset phase raises `bus_err` in the same cycle and changes no state.
- R6: A read during the reset phase returns exactly 0x00000001, with bit 0 reporting that the reset is in progress.
- R7: A write to the run bit (bit 1) reads back in the next cycle. `en_busy` is then high. It falls within 20 bus cycles, and at that point `core_en` equals the written value.
- R8: A write of bit 1 made while `en_busy` is high leaves the run bit unchanged.
- R9: The configuration field, bits [CFG_W+1:2], is written only when the run bit is clear and the core's acknowledgement is low. Otherwise that part of the write is ignored. The run bit and the reset bit are never protected this way.
- R10: Bits above the configuration field always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_b | input | 1 | Bus clock |
| rst_bn | input | 1 | Bus-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data of the control word |
| bus_err | output | 1 | Current write refused because a reset is in progress |
| en_busy | output | 1 | Run-bit handshake in flight |
| rst_busy | output | 1 | Reset phase in progress |
| cfg_q | output | CFG_W | Current configuration field |
| clk_c | input | 1 | Core clock |
| rst_cn | input | 1 | Core-domain asynchronous reset, active low |
| core_en | output | 1 | Run level in the core domain |
| core_rst | output | 1 | Reset request level in the core domain |

## Verification
Suppose the run bit and the core acknowledgement disagree without the busy flag showing it. Then a write that should be guarded would change `cfg_q` in the cycle after the write, or the busy flag would never fall and the bounded wait would expire. Suppose instead the reset phase starts or ends at the wrong time. That shows at the ports within one cycle of a write, as a missing or spurious `bus_err`, or as read data other than 0x1. A reset phase that never ends shows up as the same kind of timeout. Every expectation is taken at the falling bus edge after the edge that updates the register, so a wrong priority between reset and other fields shows up in the first read-back.

// File: rtl/ctl_sync_reg_pkg.sv
package ctl_sync_reg_pkg;
  localparam int RST_BIT = 0;
  localparam int EN_BIT  = 1;
  localparam int CFG_LSB = 2;
  localparam int CH_EN   = 0;
  localparam int CH_RST  = 1;
  localparam int N_CH    = 2;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_RESET,
    WR_NORMAL,
    WR_REJECT
  } wr_kind_e;
endpackage

// File: rtl/ctl_level_sync.sv
module ctl_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_s,
  input  logic rst_sn,
  input  logic req,
  input  logic clk_d,
  input  logic rst_dn,
  output logic lvl_d,
  output logic ack
);
  logic [STAGES-1:0] fwd;
  logic [STAGES-1:0] back;

  always_ff @(posedge clk_d or negedge rst_dn) begin
    if (!rst_dn) fwd <= '0;
    else         fwd <= {fwd[STAGES-2:0], req};
  end
  assign lvl_d = fwd[STAGES-1];

  always_ff @(posedge clk_s or negedge rst_sn) begin
    if (!rst_sn) back <= '0;
    else         back <= {back[STAGES-2:0], lvl_d};
  end
  assign ack = back[STAGES-1];
endmodule

// File: rtl/ctl_access.sv
module ctl_access
  import ctl_sync_reg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          rst_on,
  input  logic          en_busy,
  input  logic          protect,
  output wr_kind_e      wr_kind,
  output logic          en_load,
  output logic          cfg_load,
  output logic          bus_err
);
  always_comb begin
    wr_kind = WR_NONE;
    if (wr_en) begin
      if (rst_on)              wr_kind = WR_REJECT;
      else if (wdata[RST_BIT]) wr_kind = WR_RESET;
      else                     wr_kind = WR_NORMAL;
    end
  end

  assign en_load  = (wr_kind == WR_NORMAL) && !en_busy;
  assign cfg_load = (wr_kind == WR_NORMAL) && !protect;
  assign bus_err  = (wr_kind == WR_REJECT);
endmodule

// File: rtl/ctl_sync_reg.sv
module ctl_sync_reg
  import ctl_sync_reg_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CFG_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_b,
  input  logic             rst_bn,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             bus_err,
  output logic             en_busy,
  output logic             rst_busy,
  output logic [CFG_W-1:0] cfg_q,
  input  logic             clk_c,
  input  logic             rst_cn,
  output logic             core_en,
  output logic             core_rst
);
  logic            en_q;
  logic            rst_q;
  logic [N_CH-1:0] req_v;
  logic [N_CH-1:0] lvl_v;
  logic [N_CH-1:0] ack_v;
  logic            protect;
  logic            en_load;
  logic            cfg_load;
  wr_kind_e        wr_kind;

  function automatic logic [DW-1:0] read_word(input logic [CFG_W-1:0] c,
                                              input logic e,
                                              input logic r);
    logic [DW-1:0] w;
    w = '0;
    if (r) begin
      w[RST_BIT] = 1'b1;
    end else begin
      w[EN_BIT]          = e;
      w[CFG_LSB +: CFG_W] = c;
    end
    return w;
  endfunction

  assign req_v[CH_EN]  = en_q;
  assign req_v[CH_RST] = rst_q;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    ctl_level_sync #(.STAGES(STAGES)) u_sync (
      .clk_s  (clk_b),
      .rst_sn (rst_bn),
      .req    (req_v[ch]),
      .clk_d  (clk_c),
      .rst_dn (rst_cn),
      .lvl_d  (lvl_v[ch]),
      .ack    (ack_v[ch])
    );
  end

  assign rst_busy = rst_q | ack_v[CH_RST];
  assign en_busy  = en_q ^ ack_v[CH_EN];
  assign protect  = en_q | ack_v[CH_EN];
  assign core_en  = lvl_v[CH_EN];
  assign core_rst = lvl_v[CH_RST];

  ctl_access #(.DW(DW)) u_access (
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rst_on   (rst_busy),
    .en_busy  (en_busy),
    .protect  (protect),
    .wr_kind  (wr_kind),
    .en_load  (en_load),
    .cfg_load (cfg_load),
    .bus_err  (bus_err)
  );

  always_ff @(posedge clk_b or negedge rst_bn) begin
    if (!rst_bn) begin
      en_q  <= 1'b0;
      rst_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      if (rst_q && ack_v[CH_RST]) rst_q <= 1'b0;
      case (wr_kind)
        WR_RESET: begin
          rst_q <= 1'b1;
          en_q  <= 1'b0;
          cfg_q <= '0;
        end
        WR_NORMAL: begin
          if (en_load)  en_q  <= wdata[EN_BIT];
          if (cfg_load) cfg_q <= wdata[CFG_LSB +: CFG_W];
        end
        default: ;
      endcase
    end
  end

  assign rdata = read_word(cfg_q, en_q, rst_busy);

  AST_RST_CLEARS: assert property (@(posedge clk_b) disable iff (!rst_bn)
    (wr_kind == WR_RESET) |=> (cfg_q == '0 && !en_q && rst_busy)); // R2
  AST_NO_SPURIOUS_RST: assert property (@(posedge clk_b) disable iff (!rst_bn)
    (wr_en && !wdata[RST_BIT] && !rst_busy) |=> !rst_busy); // R3
  AST_ERR_ONLY_IN_RST: assert property (@(posedge clk_b) disable iff (!rst_bn)
    bus_err |-> rst_busy); // R5
  AST_REJECT_NO_EFFECT: assert property (@(posedge clk_b) disable iff (!rst_bn)
    bus_err |=> ($stable(cfg_q) && $stable(en_q))); // R5
  AST_RD_IN_RST: assert property (@(posedge clk_b) disable iff (!rst_bn)
    rst_busy |-> (rdata == DW'(1))); // R6
  AST_EN_HOLD_BUSY: assert property (@(posedge clk_b) disable iff (!rst_bn)
    (wr_en && en_busy && !rst_busy && !wdata[RST_BIT]) |=> $stable(en_q)); // R8
  AST_CFG_PROTECT: assert property (@(posedge clk_b) disable iff (!rst_bn)
    (wr_en && protect && !rst_busy && !wdata[RST_BIT]) |=> $stable(cfg_q)); // R9
endmodule

// File: tb/ctl_sync_reg_bench.sv
module ctl_sync_reg_bench;
  localparam int K_RD   = 0;
  localparam int K_ERR  = 1;
  localparam int K_ENB  = 2;
  localparam int K_RSTB = 3;
  localparam int K_CEN  = 4;
  localparam int K_CFG  = 5;

  logic        clk_b = 1'b0;
  logic        clk_c = 1'b0;
  logic        rst_bn = 1'b0;
  logic        rst_cn = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bus_err, en_busy, rst_busy, core_en, core_rst;
  logic [15:0] cfg_q;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  bit  saw_core_rst = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk_b = ~clk_b;
  always #7  clk_c = ~clk_c;

  ctl_sync_reg u_ctl_sync_reg (
    .clk_b(clk_b), .rst_bn(rst_bn), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .bus_err(bus_err), .en_busy(en_busy), .rst_busy(rst_busy),
    .cfg_q(cfg_q), .clk_c(clk_c), .rst_cn(rst_cn), .core_en(core_en),
    .core_rst(core_rst)
  );

  function automatic logic [31:0] observe(int k);
    case (k)
      K_RD:    return rdata;
      K_ERR:   return {31'b0, bus_err};
      K_ENB:   return {31'b0, en_busy};
      K_RSTB:  return {31'b0, rst_busy};
      K_CEN:   return {31'b0, core_en};
      default: return {16'b0, cfg_q};
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk_b) begin : monitor
    exp_t it;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      check(observe(it.kind), it.exp, it.tag);
    end
  end

  always @(posedge clk_c) if (core_rst) saw_core_rst = 1'b1;

  task automatic expect_v(int kind, logic [31:0] v, string tag);
    exp_t it;
    it.kind = kind; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic settle();
    @(posedge clk_b); #2;
  endtask

  task automatic bus_write(logic [31:0] d, logic exp_err, string tag);
    @(posedge clk_b); #2;
    wr_en = 1'b1; wdata = d;
    expect_v(K_ERR, {31'b0, exp_err}, tag);
    @(posedge clk_b); #2;
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic wait_low(int kind, int max_cyc, string tag);
    int n = 0;
    while (n < max_cyc) begin
      @(negedge clk_b);
      if (observe(kind) == 32'd0) break;
      n++;
    end
    check({31'b0, n < max_cyc}, 32'd1, tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk_b);
    #2; rst_bn = 1'b1; rst_cn = 1'b1;
    // R1 reset state
    expect_v(K_RD, 32'h0, "R1 rdata");
    expect_v(K_CFG, 32'h0, "R1 cfg");
    expect_v(K_ENB, 32'h0, "R1 en_busy");
    expect_v(K_RSTB, 32'h0, "R1 rst_busy");
    expect_v(K_CEN, 32'h0, "R1 core_en");
    settle();

    // R9 config write while stopped
    bus_write(32'h0000_48D0, 1'b0, "R5 no err");
    expect_v(K_RD, 32'h0000_48D0, "R9 rdata");
    expect_v(K_CFG, 32'h1234, "R9 cfg");
    expect_v(K_ENB, 32'h0, "R7 no busy");
    settle();

    // R7 run bit plus config in one write from stopped state
    bus_write(32'h0000_02AE, 1'b0, "R5 no err");
    expect_v(K_RD, 32'h0000_02AE, "R7 readback");
    expect_v(K_ENB, 32'h1, "R7 busy");
    expect_v(K_CFG, 32'h00AB, "R9 cfg");
    // R8 change while busy ignored
    bus_write(32'h0000_02AC, 1'b0, "R5 no err");
    expect_v(K_RD, 32'h0000_02AE, "R8 run held");
    settle();
    wait_low(K_ENB, 20, "R7 busy clears");
    expect_v(K_CEN, 32'h1, "R7 core_en");
    settle();

    // R9 protected while running, R3 no reset from zero bit
    bus_write(32'h0001_5556, 1'b0, "R5 no err");
    expect_v(K_CFG, 32'h00AB, "R9 protected");
    expect_v(K_RSTB, 32'h0, "R3 no reset");
    expect_v(K_RD, 32'h0000_02AE, "R9 rdata");
    settle();

    // R2 reset overrides, R6 read during reset, R5 write refused
    saw_core_rst = 1'b0;
    bus_write(32'hFFFF_FFFF, 1'b0, "R2 reset accepted");
    expect_v(K_RSTB, 32'h1, "R2 rst_busy");
    expect_v(K_RD, 32'h1, "R6 read in reset");
    expect_v(K_CFG, 32'h0, "R2 cfg cleared");
    bus_write(32'h0000_0008, 1'b1, "R5 bus_err");
    expect_v(K_CFG, 32'h0, "R5 no effect");
    expect_v(K_RD, 32'h1, "R6 read in reset");
    settle();
    wait_low(K_RSTB, 30, "R4 reset ends");
    expect_v(K_RD, 32'h0, "R4 word zero");
    settle();
    check({31'b0, saw_core_rst}, 32'd1, "R4 core_rst seen");
    wait_low(K_ENB, 20, "R2 disable completes");
    expect_v(K_CEN, 32'h0, "R2 core stopped");
    settle();

    // R10 upper bits read zero
    bus_write(32'hFFFF_FFFE, 1'b0, "R5 no err");
    expect_v(K_RD, 32'h0003_FFFE, "R10 upper zero");
    expect_v(K_CFG, 32'hFFFF, "R9 full cfg");
    settle();
    settle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule